// File: doc/BRIEF.md
# Configurable Serial Data Expansion Register

This block is one segment of a serial shift ring. It lengthens the process data of a fieldbus protocol chip by zero to six 16-bit words. Bits arrive on `sdi` and move one place on each rising clock edge on which `shift_en` is high. The oldest bit of the active window is driven on `sdo`. The clock is forwarded on `clk_out`, so that further segments can be chained behind this one.

Two strobes move data between the ring and the parallel holding registers:
- `in_latch` copies the inbound holding bytes into the chain for transmission. The bytes are written through a simple byte port.
- `out_latch` copies the chain contents into the outbound holding bytes. These bytes are presented on `out_q`.

The segment length is taken from either the three strap inputs or a configuration field from a companion register block. The value is captured on every `in_latch`. A power-up reset clears everything. A separate register clear empties the data storage only.

Top module: `ser_expander`

## Requirements
- R1: After power-up reset (`rst_n` low), `out_q` is all zero and `sdo` is 0.
- R2: The length code is `cfg_len` when `cfg_sel` is 1 and `strap` when `cfg_sel` is 0. Codes 0 to 6 select that many 16-bit words. Code 7 selects 0 words. The input that is not selected has no effect.
- R3: `in_latch` loads inbound byte k (written with `in_addr` = k, for k from 0 to 11) into the chain. The chain is ordered so that byte 0 leaves first, MSB first, then byte 1, and so on. Right after the latch edge, `sdo` shows bit 7 of byte 0, and each shift presents the next bit. Bytes at or beyond twice the word count are not sent. Writes with `in_addr` ≥ 12 are ignored.
- R4: `sdi` is sampled on a rising edge of `clk` while `shift_en` is 1. After exactly 16×N shifts at length N, the first bit shifted in sits at bit 7 of byte 0.
- R5: At length 0, `sdo` equals the `sdi` value captured at the previous shift, through one flop.
- R6: The length used for shifting changes only on an `in_latch` edge. Strap or configuration changes at any other time have no effect until the next `in_latch`.
- R7: While `reg_clr_n` is low, the inbound bytes, outbound bytes and chain are 0. The captured length is kept.
- R8: When `out_latch` and `in_latch` fall in the same cycle, `out_q` receives the chain contents as they were before the inbound load.
- R9: `clk_out` follows `clk`.
- R10: `out_latch` places byte k at `out_q[95-8k -: 8]` for k below twice the word count, and sets all other bytes of `out_q` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Power-up reset, active low, clears all state |
| reg_clr_n | input | 1 | Data register clear, active low |
| clk_out | output | 1 | Forwarded clock for chained segments |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| shift_en | input | 1 | Shift the chain by one bit |
| out_latch | input | 1 | Copy the chain to the outbound bytes |
| in_latch | input | 1 | Load the inbound bytes into the chain and capture the length |
| strap | input | 3 | Hardware length code |
| cfg_sel | input | 1 | 1 selects `cfg_len`, 0 selects `strap` |
| cfg_len | input | 3 | Configured length code |
| in_we | input | 1 | Inbound byte write enable |
| in_addr | input | 4 | Inbound byte index |
| in_byte | input | 8 | Inbound byte value |
| out_q | output | 96 | Outbound bytes, byte 0 in the top eight bits |

## Verification
The two functions that can fall in one cycle are capturing the outbound data and reloading the chain with inbound data. The bench shifts a known pattern in at length 2, writes new inbound bytes, and then raises both strobes on the same edge. It then checks that `out_q` holds the shifted-in pattern and not the new inbound bytes. It also checks that the following shifts present those new bytes on `sdo`, in order.

// File: rtl/ser_expander.sv
module ser_expander #(
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 6,
  parameter int ADDR_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_clr_n,
  output logic                        clk_out,
  input  logic                        sdi,
  output logic                        sdo,
  input  logic                        shift_en,
  input  logic                        out_latch,
  input  logic                        in_latch,
  input  logic [2:0]                  strap,
  input  logic                        cfg_sel,
  input  logic [2:0]                  cfg_len,
  input  logic                        in_we,
  input  logic [ADDR_W-1:0]           in_addr,
  input  logic [7:0]                  in_byte,
  output logic [WORD_W*MAX_WORDS-1:0] out_q
);
  localparam int NBITS  = WORD_W * MAX_WORDS;
  localparam int NBYTES = NBITS / 8;
  localparam int BPW    = WORD_W / 8;

  logic [7:0]       in_r [NBYTES];
  logic [NBITS-1:0] ch, ch_shift, ch_load, ch_cap;
  logic [2:0]       act_len, sel_code, new_len;
  logic             byp;
  int               pos;

  assign clk_out  = clk;
  assign sel_code = cfg_sel ? cfg_len : strap;
  assign new_len  = (int'(sel_code) > MAX_WORDS) ? 3'd0 : sel_code;
  assign sdo      = (act_len == 3'd0) ? byp : ch[NBITS-1];

  always_comb begin
    pos = NBITS - WORD_W * int'(act_len);
    ch_shift = '0;
    ch_shift[0] = (pos == 0) ? sdi : 1'b0;
    for (int i = 1; i < NBITS; i++) begin
      if (i == pos)     ch_shift[i] = sdi;
      else if (i > pos) ch_shift[i] = ch[i-1];
    end
  end

  always_comb begin
    ch_load = '0;
    ch_cap  = '0;
    for (int k = 0; k < NBYTES; k++) begin
      if (k < BPW * int'(new_len)) ch_load[NBITS-1-8*k -: 8] = in_r[k];
      if (k < BPW * int'(act_len)) ch_cap[NBITS-1-8*k -: 8]  = ch[NBITS-1-8*k -: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_len <= '0;
      byp     <= 1'b0;
    end else begin
      if (in_latch) act_len <= new_len;
      if (shift_en) byp <= sdi;
    end
  end

  always_ff @(posedge clk or negedge rst_n or negedge reg_clr_n) begin
    if (!rst_n || !reg_clr_n) begin
      ch    <= '0;
      out_q <= '0;
      for (int k = 0; k < NBYTES; k++) in_r[k] <= '0;
    end else begin
      if (in_we && int'(in_addr) < NBYTES) in_r[in_addr] <= in_byte;
      if (out_latch) out_q <= ch_cap;
      if (in_latch)      ch <= ch_load;
      else if (shift_en) ch <= ch_shift;
    end
  end

  assert_len_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(act_len) <= MAX_WORDS);

  assert_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !in_latch && act_len == 3'd0) |=> (sdo == $past(sdi)));

  assert_len_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_latch |=> $stable(act_len));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_clr_n |-> (out_q == '0 && ch == '0));

  assert_clear_keeps_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_clr_n && !in_latch) |=> $stable(act_len));
endmodule

// File: tb/ser_expander_bench.sv
module ser_expander_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        sel;
    logic [2:0]  code;
    logic [2:0]  words;
    logic [31:0] seed;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 3'd1, 3'd1, 32'h1234_5678},
    '{1'b0, 3'd3, 3'd3, 32'h9E37_79B9},
    '{1'b1, 3'd6, 3'd6, 32'hC0FF_EE01},
    '{1'b0, 3'd6, 3'd6, 32'h0BAD_F00D},
    '{1'b1, 3'd2, 3'd2, 32'h7F00_80FF},
    '{1'b0, 3'd7, 3'd0, 32'h5A5A_3C3C},
    '{1'b1, 3'd0, 3'd0, 32'hDEAD_BEEF},
    '{1'b1, 3'd5, 3'd5, 32'h2468_ACE1}
  };

  logic clk = 0, rst_n = 0, reg_clr_n = 1;
  logic sdi = 0, shift_en = 0, out_latch = 0, in_latch = 0;
  logic [2:0] strap = 0, cfg_len = 0;
  logic cfg_sel = 0, in_we = 0;
  logic [3:0] in_addr = 0;
  logic [7:0] in_byte = 0;
  logic clk_out, sdo;
  logic [95:0] out_q;
  int nvec = 0, nbad = 0;

  ser_expander u_ser_expander (
    .clk(clk), .rst_n(rst_n), .reg_clr_n(reg_clr_n), .clk_out(clk_out),
    .sdi(sdi), .sdo(sdo), .shift_en(shift_en), .out_latch(out_latch),
    .in_latch(in_latch), .strap(strap), .cfg_sel(cfg_sel), .cfg_len(cfg_len),
    .in_we(in_we), .in_addr(in_addr), .in_byte(in_byte), .out_q(out_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  function automatic logic [95:0] top(input logic [95:0] v, input int nb);
    return (nb == 0) ? '0 : (v & ~({96{1'b1}} >> nb));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_in(input logic [95:0] p);
    for (int k = 0; k < 12; k++) begin
      in_we = 1; in_addr = 4'(k); in_byte = p[95-8*k -: 8];
      @(negedge clk);
    end
    in_we = 0;
  endtask

  task automatic pulse_in();
    in_latch = 1; @(negedge clk); in_latch = 0;
  endtask

  task automatic pulse_out();
    out_latch = 1; @(negedge clk); out_latch = 0;
  endtask

  task automatic shift_frame(input int nb, input logic [95:0] s, input logic [95:0] expo, output int errs);
    errs = 0;
    for (int j = 0; j < nb; j++) begin
      if (sdo !== expo[95-j]) errs++;
      sdi = s[95-j]; shift_en = 1;
      @(negedge clk);
    end
    shift_en = 0;
  endtask

  initial begin
    logic [95:0] inpat, serpat, p2;
    int errs, nb;
    @(negedge clk); @(negedge clk);
    chk(out_q == '0 && sdo == 1'b0, "R1 reset state", out_q, '0);
    rst_n = 1;
    @(negedge clk);
    chk(clk_out == clk, "R9 clk_out low phase", 96'(clk_out), 96'(clk));
    #(CLK_PERIOD/2);
    chk(clk_out == clk, "R9 clk_out high phase", 96'(clk_out), 96'(clk));
    @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      inpat  = {VECS[v].seed, ~VECS[v].seed, VECS[v].seed ^ 32'h0F0F_F0F0};
      serpat = {~VECS[v].seed ^ 32'h5555_AAAA, VECS[v].seed, ~VECS[v].seed};
      nb = 16 * int'(VECS[v].words);
      cfg_sel = VECS[v].sel;
      if (VECS[v].sel) begin cfg_len = VECS[v].code; strap = VECS[v].code ^ 3'b011; end
      else begin strap = VECS[v].code; cfg_len = VECS[v].code ^ 3'b011; end
      write_in(inpat);
      pulse_in();
      if (nb == 0) begin
        errs = 0;
        for (int j = 0; j < 8; j++) begin
          sdi = serpat[95-j]; shift_en = 1;
          @(negedge clk);
          if (sdo !== serpat[95-j]) errs++;
        end
        shift_en = 0;
        chk(errs == 0, "R5 R2 zero-length bypass", 96'(errs), '0);
      end else begin
        shift_frame(nb, serpat, top(inpat, nb), errs);
        chk(errs == 0, "R3 R2 serial output order", 96'(errs), '0);
      end
      pulse_out();
      chk(out_q == top(serpat, nb), "R4 R10 R2 outbound capture", out_q, top(serpat, nb));
    end

    cfg_sel = 0; strap = 3'd2;
    inpat = 96'hA1B2_C3D4_E5F6_0718_293A_4B5C;
    serpat = 96'h3C5A_96E1_0000_0000_0000_0000;
    write_in(inpat);
    pulse_in();
    strap = 3'd6;
    shift_frame(32, serpat, top(inpat, 32), errs);
    chk(errs == 0, "R6 stream with strap changed mid-frame", 96'(errs), '0);
    pulse_out();
    chk(out_q == top(serpat, 32), "R6 length held until next load", out_q, top(serpat, 32));

    reg_clr_n = 0;
    #1;
    chk(out_q == '0, "R7 outbound cleared", out_q, '0);
    @(negedge clk);
    reg_clr_n = 1;
    @(negedge clk);
    p2 = 96'hF00F_1EE1_0000_0000_0000_0000;
    shift_frame(32, p2, '0, errs);
    pulse_out();
    chk(out_q == top(p2, 32), "R7 length kept across clear", out_q, top(p2, 32));
    strap = 3'd2;
    pulse_in();
    shift_frame(32, '0, '0, errs);
    chk(errs == 0, "R7 inbound bytes cleared", 96'(errs), '0);

    write_in(96'hFFFF_FFFF_0000_0000_0000_0000);
    pulse_in();
    serpat = 96'h1357_9BDF_0000_0000_0000_0000;
    shift_frame(32, serpat, top(96'hFFFF_FFFF_0000_0000_0000_0000, 32), errs);
    inpat = 96'h8421_C6E7_1111_2222_3333_4444;
    write_in(inpat);
    in_addr = 4'd12; in_byte = 8'h00; in_we = 1;
    @(negedge clk);
    in_we = 0;
    out_latch = 1; in_latch = 1;
    @(negedge clk);
    out_latch = 0; in_latch = 0;
    chk(out_q == top(serpat, 32), "R8 outbound takes pre-load chain", out_q, top(serpat, 32));
    shift_frame(32, '0, top(inpat, 32), errs);
    chk(errs == 0, "R8 R3 new inbound data follows", 96'(errs), '0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule